// File: doc/BRIEF.md
# Flash Write-Enable and Busy Status Controller

This block holds the two status bits that decide whether a serial flash device may modify its contents: the write-enable latch (WEL) and the busy flag (BUSY). A command decoder upstream presents one strobe per decoded command in the cycle the command is issued. The block combines those strobes with the current state and returns a combinational `cmd_accept`. An accepted command updates the latch and the operation phase on the next clock edge. A rejected strobe changes nothing.

A modifying command runs only when the latch was set before it was issued. Every modifying command clears the latch, whether it starts, is dropped, or is blocked by protection. A blocked program or erase never raises BUSY. A running program or erase can be suspended. During suspension BUSY reads 0 and WEL is cleared. Resume sets both bits again, and BUSY then stays high until `op_done`. The block has no data stream, so all pins are plain level or strobe controls with no back-pressure. The upstream decoder asserts at most one command strobe per cycle. If it asserts several, the lowest-numbered strobe in the port list wins.

Top module: `flash_wel_busy_ctrl`

## Requirements
- R1: After reset, `wel` and `busy` are 0 and `sts_bits` is 2'b00. `sts_bits[0]` is BUSY and `sts_bits[1]` is WEL.
- R2: When not busy and not suspended, an accepted write-enable sets `wel` on the next cycle. An accepted write-disable clears it. Both are also accepted while suspended.
- R3: While idle, any of program, erase, status write, security erase or security program is accepted. If `wel` was 1 and the command is not blocked, the next cycle shows `busy`=1 and `wel`=0.
- R4: A modifying command issued with `wel`=0 is dropped: `busy` stays 0 and `wel` stays 0.
- R5: A program or erase issued with `prot_block`=1 clears `wel` and leaves `busy` at 0. `prot_block` has no effect on status write or the security commands.
- R6: While `busy`=1, `cmd_accept` is 1 only for read-status and for an allowed suspend. Every other strobe is rejected and leaves `wel` and `busy` unchanged.
- R7: `op_done` while busy clears `busy` on the next cycle. A suspend in that same cycle is rejected.
- R8: Suspend is accepted only while a program or erase is running. The next cycle shows `busy`=0 and `wel`=0. Suspend is rejected while idle or during a status write or security command.
- R9: While suspended, the modifying commands and suspend are rejected. Read-status, write-enable, write-disable and resume are accepted.
- R10: An accepted resume gives `busy`=1 and `wel`=1 on the next cycle. `busy` then stays high until `op_done`.
- R11: `cmd_accept` settles within the same cycle as the strobe. Read-status and rejected strobes leave `wel` and `busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_rdsr | input | 1 | Read-status strobe |
| cmd_prog | input | 1 | Page program strobe |
| cmd_erase | input | 1 | Sector, block or chip erase strobe |
| cmd_wrsr | input | 1 | Status-register write strobe |
| cmd_sec_erase | input | 1 | Security-register erase strobe |
| cmd_sec_prog | input | 1 | Security-register program strobe |
| cmd_suspend | input | 1 | Program/erase suspend strobe |
| cmd_resume | input | 1 | Program/erase resume strobe |
| prot_block | input | 1 | Target of the current program/erase is protected |
| op_done | input | 1 | Running operation finished |
| cmd_accept | output | 1 | Combinational: the strobed command is taken |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Operation in progress |
| sts_bits | output | 2 | {WEL, BUSY} for the status register low bits |

## Verification
The bench builds the block with `SUSPEND_EN` at its default of 1, so the suspend and resume paths are present. This makes the full idle, running and suspended cycle reachable, including suspend colliding with `op_done` and protection-blocked commands inside a suspension. With this setting every combination of phase, latch value, protection flag and completion pulse can be reached. The random stream uses one-hot strobes with frequent completion pulses so that it crosses those states many times.

// File: rtl/flash_sts_pkg.sv
package flash_sts_pkg;

  localparam int NUM_STROBES = 10;
  localparam int CMD_W       = $clog2(NUM_STROBES + 1);

  // Strobe index order sets decode priority (lowest index wins).
  typedef enum logic [CMD_W-1:0] {
    C_NONE      = 4'd0,
    C_WREN      = 4'd1,
    C_WRDI      = 4'd2,
    C_RDSR      = 4'd3,
    C_PROG      = 4'd4,
    C_ERASE     = 4'd5,
    C_WRSR      = 4'd6,
    C_SEC_ERASE = 4'd7,
    C_SEC_PROG  = 4'd8,
    C_SUSPEND   = 4'd9,
    C_RESUME    = 4'd10
  } cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_SUSP = 2'd2
  } phase_e;

  // Strobe bit i maps to command i+1.
  function automatic cmd_e idx_to_cmd(input int idx);
    return cmd_e'(CMD_W'(idx + 1));
  endfunction

  // Commands that clear the latch and may start an internal operation.
  function automatic logic is_modifying(input cmd_e c);
    return (c == C_PROG) || (c == C_ERASE) || (c == C_WRSR) ||
           (c == C_SEC_ERASE) || (c == C_SEC_PROG);
  endfunction

  // Array program/erase: subject to protection, may be suspended.
  function automatic logic is_array_op(input cmd_e c);
    return (c == C_PROG) || (c == C_ERASE);
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_sts_pkg::*;
(
  input  logic [NUM_STROBES-1:0] strobes,
  output cmd_e                   cmd
);

  // Priority encode: scan from the top so the lowest set index wins.
  always_comb begin
    cmd = C_NONE;
    for (int i = NUM_STROBES - 1; i >= 0; i--) begin
      if (strobes[i]) cmd = idx_to_cmd(i);
    end
  end

endmodule

// File: rtl/flash_cmd_filter.sv
module flash_cmd_filter
  import flash_sts_pkg::*;
#(
  parameter bit SUSPEND_EN = 1'b1
) (
  input  cmd_e   cmd,
  input  phase_e phase,
  input  logic   susp_ok,
  input  logic   op_done,
  output logic   accept
);

  logic suspend_ok_now;
  logic resume_ok_now;

  generate
    if (SUSPEND_EN) begin : g_susp
      // Suspend only a running array op, and not in its completion cycle.
      assign suspend_ok_now = (phase == PH_RUN) && susp_ok && !op_done;
      assign resume_ok_now  = (phase == PH_SUSP);
    end else begin : g_nosusp
      assign suspend_ok_now = 1'b0;
      assign resume_ok_now  = 1'b0;
    end
  endgenerate

  always_comb begin
    accept = 1'b0;
    unique case (phase)
      PH_RUN: begin
        accept = (cmd == C_RDSR) || ((cmd == C_SUSPEND) && suspend_ok_now);
      end
      PH_SUSP: begin
        accept = (cmd == C_RDSR) || (cmd == C_WREN) || (cmd == C_WRDI) ||
                 ((cmd == C_RESUME) && resume_ok_now);
      end
      PH_IDLE: begin
        accept = (cmd != C_NONE) && (cmd != C_SUSPEND) && (cmd != C_RESUME);
      end
      default: accept = 1'b0;
    endcase
  end

endmodule

// File: rtl/flash_sts_core.sv
module flash_sts_core
  import flash_sts_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cmd_e   cmd,
  input  logic   accept,
  input  logic   prot_block,
  input  logic   op_done,
  output logic   wel,
  output phase_e phase,
  output logic   susp_ok
);

  logic blocked;
  logic may_start;

  assign blocked   = prot_block && is_array_op(cmd);
  assign may_start = wel && !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel     <= 1'b0;
      phase   <= PH_IDLE;
      susp_ok <= 1'b0;
    end else if ((phase == PH_RUN) && op_done) begin
      // Completion has priority; the filter rejects suspend here.
      phase   <= PH_IDLE;
      susp_ok <= 1'b0;
    end else if (accept) begin
      unique case (cmd)
        C_WREN: wel <= 1'b1;
        C_WRDI: wel <= 1'b0;
        C_PROG, C_ERASE, C_WRSR, C_SEC_ERASE, C_SEC_PROG: begin
          wel <= 1'b0;
          if (may_start) begin
            phase   <= PH_RUN;
            susp_ok <= is_array_op(cmd);
          end
        end
        C_SUSPEND: begin
          phase <= PH_SUSP;
          wel   <= 1'b0;
        end
        C_RESUME: begin
          phase <= PH_RUN;
          wel   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flash_wel_busy_ctrl.sv
module flash_wel_busy_ctrl
  import flash_sts_pkg::*;
#(
  parameter bit SUSPEND_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wren,
  input  logic       cmd_wrdi,
  input  logic       cmd_rdsr,
  input  logic       cmd_prog,
  input  logic       cmd_erase,
  input  logic       cmd_wrsr,
  input  logic       cmd_sec_erase,
  input  logic       cmd_sec_prog,
  input  logic       cmd_suspend,
  input  logic       cmd_resume,
  input  logic       prot_block,
  input  logic       op_done,
  output logic       cmd_accept,
  output logic       wel,
  output logic       busy,
  output logic [1:0] sts_bits
);

  logic [NUM_STROBES-1:0] strobes;
  cmd_e                   cmd;
  phase_e                 phase;
  logic                   susp_ok;

  assign strobes = {cmd_resume, cmd_suspend, cmd_sec_prog, cmd_sec_erase,
                    cmd_wrsr, cmd_erase, cmd_prog, cmd_rdsr, cmd_wrdi, cmd_wren};

  flash_cmd_decode u_dec (
    .strobes (strobes),
    .cmd     (cmd)
  );

  flash_cmd_filter #(.SUSPEND_EN(SUSPEND_EN)) u_flt (
    .cmd     (cmd),
    .phase   (phase),
    .susp_ok (susp_ok),
    .op_done (op_done),
    .accept  (cmd_accept)
  );

  flash_sts_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .accept     (cmd_accept),
    .prot_block (prot_block),
    .op_done    (op_done),
    .wel        (wel),
    .phase      (phase),
    .susp_ok    (susp_ok)
  );

  assign busy     = (phase == PH_RUN);
  assign sts_bits = {wel, busy};

endmodule

// File: rtl/flash_sts_checker.sv
module flash_sts_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_rdsr,
  input logic       cmd_prog,
  input logic       cmd_erase,
  input logic       cmd_wrsr,
  input logic       cmd_sec_erase,
  input logic       cmd_sec_prog,
  input logic       cmd_suspend,
  input logic       cmd_resume,
  input logic       prot_block,
  input logic       op_done,
  input logic       cmd_accept,
  input logic       wel,
  input logic       busy,
  input logic [1:0] sts_bits
);

  logic [9:0] stb;
  logic       single;
  logic       modc;
  logic       arr;

  assign stb    = {cmd_resume, cmd_suspend, cmd_sec_prog, cmd_sec_erase,
                   cmd_wrsr, cmd_erase, cmd_prog, cmd_rdsr, cmd_wrdi, cmd_wren};
  assign single = ($countones(stb) == 1);
  assign modc   = cmd_prog | cmd_erase | cmd_wrsr | cmd_sec_erase | cmd_sec_prog;
  assign arr    = cmd_prog | cmd_erase;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (!wel && !busy));

  p_wren_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (single && cmd_wren && cmd_accept) |=> wel);

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (single && modc && cmd_accept && wel && !(prot_block && arr)) |=> (busy && !wel));

  p_nowel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (single && modc && cmd_accept && !wel) |=> (!busy && !wel));

  p_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (single && arr && cmd_accept && prot_block) |=> (!busy && !wel));

  p_busy_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && single && !cmd_rdsr && !cmd_suspend) |-> !cmd_accept);

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> !busy);

  p_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (single && cmd_suspend && cmd_accept) |=> (!busy && !wel));

  p_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (single && cmd_resume && cmd_accept) |=> (busy && wel));

  p_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_accept && !(busy && op_done)) |=> ($stable(wel) && $stable(busy)));

  p_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sts_bits == {wel, busy});

endmodule

bind flash_wel_busy_ctrl flash_sts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
  .cmd_rdsr(cmd_rdsr), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
  .cmd_wrsr(cmd_wrsr), .cmd_sec_erase(cmd_sec_erase),
  .cmd_sec_prog(cmd_sec_prog), .cmd_suspend(cmd_suspend),
  .cmd_resume(cmd_resume), .prot_block(prot_block), .op_done(op_done),
  .cmd_accept(cmd_accept), .wel(wel), .busy(busy), .sts_bits(sts_bits)
);

// File: tb/sim_flash_wel_busy_ctrl.sv
`timescale 1ns/1ps
module sim_flash_wel_busy_ctrl;

  // Strobe indices: 0 wren,1 wrdi,2 rdsr,3 prog,4 erase,5 wrsr,
  // 6 sec_erase,7 sec_prog,8 suspend,9 resume
  localparam int WREN = 0, WRDI = 1, RDSR = 2, PROG = 3, ERASE = 4,
                 WRSR = 5, SECE = 6, SECP = 7, SUSP = 8, RES = 9, NONE = -1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] stb = '0;
  logic       prot_i = 1'b0;
  logic       done_i = 1'b0;
  logic       cmd_accept, wel, busy;
  logic [1:0] sts_bits;

  always #10 clk = ~clk;

  flash_wel_busy_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_wren(stb[0]), .cmd_wrdi(stb[1]), .cmd_rdsr(stb[2]),
    .cmd_prog(stb[3]), .cmd_erase(stb[4]), .cmd_wrsr(stb[5]),
    .cmd_sec_erase(stb[6]), .cmd_sec_prog(stb[7]),
    .cmd_suspend(stb[8]), .cmd_resume(stb[9]),
    .prot_block(prot_i), .op_done(done_i),
    .cmd_accept(cmd_accept), .wel(wel), .busy(busy), .sts_bits(sts_bits)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    m_wel = 0;
  int    m_ph  = 0;   // 0 idle, 1 running, 2 suspended
  bit    m_sok = 0;
  string cur_tag = "R1";

  function automatic bit is_mod(int c);
    return (c >= PROG) && (c <= SECP);
  endfunction

  function automatic bit exp_acc(int c, bit done);
    if (c < 0) return 0;
    if (m_ph == 1) return (c == RDSR) || (c == SUSP && m_sok && !done);
    if (m_ph == 2) return (c == RDSR) || (c == WREN) || (c == WRDI) || (c == RES);
    return (c != SUSP) && (c != RES);
  endfunction

  function automatic string tag_of(int c, bit prot, bit done, bit acc);
    if (m_ph == 1 && done) return "R7";
    if (!acc) return (m_ph == 1) ? "R6" : (m_ph == 2) ? "R9" : "R11";
    if (c == WREN || c == WRDI) return "R2";
    if (c == RDSR) return "R11";
    if (is_mod(c)) begin
      if (!m_wel) return "R4";
      if (prot && (c == PROG || c == ERASE)) return "R5";
      return "R3";
    end
    if (c == SUSP) return "R8";
    return "R10";
  endfunction

  task automatic step_model(int c, bit prot, bit done, bit acc);
    bit arr;
    if (m_ph == 1 && done) begin
      m_ph = 0; m_sok = 0;
    end else if (acc) begin
      case (c)
        WREN: m_wel = 1;
        WRDI: m_wel = 0;
        SUSP: begin m_ph = 2; m_wel = 0; end
        RES:  begin m_ph = 1; m_wel = 1; end
        RDSR: ;
        default: begin
          arr = (c == PROG) || (c == ERASE);
          if (m_wel && !(prot && arr)) begin m_ph = 1; m_sok = arr; end
          m_wel = 0;
        end
      endcase
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    chk(tag, "wel", wel, m_wel);
    chk(tag, "busy", busy, (m_ph == 1));
    chk(tag, "sts_bits", sts_bits, {m_wel, (m_ph == 1)});
  endtask

  task automatic apply(int c, bit prot, bit done, string tag);
    bit    acc;
    string t;
    @(negedge clk);
    check_state(cur_tag);
    stb    = (c >= 0) ? (10'b1 << c) : '0;
    prot_i = prot;
    done_i = done;
    #1;
    acc = exp_acc(c, done);
    t   = (tag == "") ? tag_of(c, prot, done, acc) : tag;
    chk(t, "cmd_accept", cmd_accept, acc);
    step_model(c, prot, done, acc);
    cur_tag = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_state("R1");
    rst_n = 1'b1;
    // Directed corners
    apply(WREN, 0, 0, "R2");
    apply(WRDI, 0, 0, "R2");
    apply(PROG, 0, 0, "R4");
    apply(WREN, 0, 0, "R2");
    apply(PROG, 1, 0, "R5");
    apply(WREN, 0, 0, "R2");
    apply(WRSR, 1, 0, "R5");     // protection ignored: starts
    apply(WREN, 0, 0, "R6");     // rejected while busy
    apply(RDSR, 0, 0, "R6");
    apply(SUSP, 0, 0, "R8");     // not suspendable
    apply(NONE, 0, 1, "R7");
    apply(SUSP, 0, 0, "R8");     // idle: rejected
    apply(WREN, 0, 0, "R2");
    apply(ERASE, 0, 0, "R3");
    apply(SUSP, 0, 1, "R7");     // collides with done
    apply(WREN, 0, 0, "R2");
    apply(PROG, 0, 0, "R3");
    apply(SUSP, 0, 0, "R8");
    apply(PROG, 0, 0, "R9");
    apply(WREN, 0, 0, "R9");
    apply(SUSP, 0, 0, "R9");
    apply(RES, 0, 0, "R10");
    apply(RDSR, 0, 0, "R10");
    apply(NONE, 0, 1, "R10");
    apply(RES, 0, 0, "R11");
    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 14);
      apply((r < 10) ? r : NONE, ($urandom % 4) == 0, ($urandom % 6) == 0, "");
    end
    @(negedge clk);
    check_state(cur_tag);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule